// File: doc/BRIEF.md
# GPIO Bank Interrupt Sense and Status

This block watches the synchronized input pins of one GPIO bank and records which pins have met their configured trigger condition. Each pin has its own trigger setting, built from one bit in each of three type registers: edge or level sensing, the polarity within that sense, and a both-edges option. A detection sets a sticky per-pin status bit. Software clears a status bit by writing a one to it.

Detection runs on every pin whether or not its enable bit is set. The single interrupt output is high whenever any pin has both its status bit and its enable bit set. A simple register port with one write strobe and a combinational read of the addressed register gives access to the five registers. The port uses byte offsets from the bank's interrupt base.

Top module: `gpio_irq_sense`

## Requirements
- R1: The registers sit at these byte offsets: enable 0x00, type0 0x04, type1 0x08, type2 0x0C, status 0x10. Enable and the three type registers read back the last value written to them. Any other offset reads zero, and a write to it changes no register.
- R2: After reset, all five registers read zero and the interrupt output is low.
- R3: With type1=0 and type0=1, a 0-to-1 change of a pin sets its status bit on the next clock edge. With type1=0 and type0=0, a 1-to-0 change sets it, and type2 has no effect.
- R4: With type1=0, type0=1 and type2=1, a change of a pin in either direction sets its status bit on the next clock edge.
- R5: With type1=1, the status bit is set on every clock edge at which the pin is at its active level: high when type0=1, low when type0=0. Clearing the bit therefore has no lasting effect while that level persists.
- R6: Writing the status offset clears each status bit whose write-data bit is 1. Bits written with 0 keep their value. Writing status never sets a bit.
- R7: When a clear and a new detection hit the same status bit at the same clock edge, the bit ends up set.
- R8: Status bits are set whatever the enable register holds. The interrupt output equals the OR over all pins of status AND enable, and it follows the registers without a further clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_in | input | WIDTH | Synchronized pin levels of the bank |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset from the interrupt base |
| reg_wdata | input | WIDTH | Write data |
| reg_rdata | output | WIDTH | Read data of the register at reg_addr |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with WIDTH=8 and the default ADDR_W=5. With eight pins, a single byte pattern can mix pins in different modes and polarities. It can also raise edges on some pins while others hold still, so every pin's status is checked against a full expected byte at once. A register value of 8 bits also makes readback and masking checks cover every bit position.

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense #(
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIDTH-1:0]  pin_in,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WIDTH-1:0]  reg_wdata,
  output logic [WIDTH-1:0]  reg_rdata,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] OFF_EN   = ADDR_W'(5'h00);
  localparam logic [ADDR_W-1:0] OFF_T0   = ADDR_W'(5'h04);
  localparam logic [ADDR_W-1:0] OFF_T1   = ADDR_W'(5'h08);
  localparam logic [ADDR_W-1:0] OFF_T2   = ADDR_W'(5'h0C);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(5'h10);

  logic [WIDTH-1:0] enable_q, type0_q, type1_q, type2_q, status_q;
  logic [WIDTH-1:0] prev_q, hit, clr;

  wire wr_en = reg_wr && (reg_addr == OFF_EN);
  wire wr_t0 = reg_wr && (reg_addr == OFF_T0);
  wire wr_t1 = reg_wr && (reg_addr == OFF_T1);
  wire wr_t2 = reg_wr && (reg_addr == OFF_T2);

  assign clr = (reg_wr && (reg_addr == OFF_STAT)) ? reg_wdata : '0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic h;
    always_comb begin
      unique case ({type1_q[i], type0_q[i]})
        2'b00:   h = prev_q[i] & ~pin_in[i];
        2'b01:   h = type2_q[i] ? (pin_in[i] ^ prev_q[i]) : (pin_in[i] & ~prev_q[i]);
        2'b10:   h = ~pin_in[i];
        default: h = pin_in[i];
      endcase
    end
    assign hit[i] = h;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
      type0_q  <= '0;
      type1_q  <= '0;
      type2_q  <= '0;
      status_q <= '0;
      prev_q   <= '0;
    end else begin
      prev_q   <= pin_in;
      status_q <= (status_q & ~clr) | hit;
      if (wr_en) enable_q <= reg_wdata;
      if (wr_t0) type0_q  <= reg_wdata;
      if (wr_t1) type1_q  <= reg_wdata;
      if (wr_t2) type2_q  <= reg_wdata;
    end
  end

  always_comb begin
    unique case (reg_addr)
      OFF_EN:   reg_rdata = enable_q;
      OFF_T0:   reg_rdata = type0_q;
      OFF_T1:   reg_rdata = type1_q;
      OFF_T2:   reg_rdata = type2_q;
      OFF_STAT: reg_rdata = status_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign irq = |(status_q & enable_q);

endmodule

module gpio_irq_sense_chk #(
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WIDTH-1:0]  pin_in,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              irq,
  input logic [WIDTH-1:0]  enable_q,
  input logic [WIDTH-1:0]  type0_q,
  input logic [WIDTH-1:0]  type1_q,
  input logic [WIDTH-1:0]  type2_q,
  input logic [WIDTH-1:0]  status_q
);

  logic             ok;
  logic [WIDTH-1:0] p_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok  <= 1'b0;
      p_q <= '0;
    end else begin
      ok  <= 1'b1;
      p_q <= pin_in;
    end
  end

  wire [WIDTH-1:0] lvl_hi  = type1_q & type0_q & pin_in;
  wire [WIDTH-1:0] rise    = ~type1_q & type0_q & ~type2_q & pin_in & ~p_q;
  wire             clr_now = reg_wr && (reg_addr == ADDR_W'(5'h10));

  a_r3_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && |rise) |=> ((status_q & $past(rise)) == $past(rise)));

  a_r5_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && |lvl_hi) |=> ((status_q & $past(lvl_hi)) == $past(lvl_hi)));

  a_r6_no_spurious_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && !clr_now) |=> (($past(status_q) & ~status_q) == '0));

  a_r8_irq_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_q == '0) |-> !irq);

  a_r8_irq_off_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == '0) |-> !irq);

endmodule

bind gpio_irq_sense gpio_irq_sense_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .irq(irq), .enable_q(enable_q), .type0_q(type0_q), .type1_q(type1_q),
  .type2_q(type2_q), .status_q(status_q)
);

// File: tb/gpio_irq_sense_tb.sv
module gpio_irq_sense_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 8;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] pin_in = '0;
  logic reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic irq;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_sense #(.WIDTH(W), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  localparam logic [AW-1:0] A_EN = 5'h00, A_T0 = 5'h04, A_T1 = 5'h08,
                            A_T2 = 5'h0C, A_ST = 5'h10;

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(string req, string what, logic [W-1:0] got, logic [W-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [W-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [W-1:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic chk_status(string req, logic [W-1:0] exp);
    logic [W-1:0] d;
    rd(A_ST, d);
    check(req, "status", d, exp);
  endtask

  task automatic t_reset();
    logic [W-1:0] d;
    rd(A_EN, d); check("R2", "enable", d, '0);
    rd(A_T0, d); check("R2", "type0", d, '0);
    rd(A_T1, d); check("R2", "type1", d, '0);
    rd(A_T2, d); check("R2", "type2", d, '0);
    rd(A_ST, d); check("R2", "status", d, '0);
    check("R2", "irq", W'(irq), '0);
  endtask

  task automatic t_cfg();
    logic [W-1:0] d;
    wr(A_EN, 8'hA5); wr(A_T0, 8'h3C); wr(A_T1, 8'h0F); wr(A_T2, 8'hF0);
    rd(A_EN, d); check("R1", "enable readback", d, 8'hA5);
    rd(A_T0, d); check("R1", "type0 readback", d, 8'h3C);
    rd(A_T1, d); check("R1", "type1 readback", d, 8'h0F);
    rd(A_T2, d); check("R1", "type2 readback", d, 8'hF0);
    wr(5'h14, 8'hFF);
    rd(5'h14, d); check("R1", "unmapped reads zero", d, '0);
    rd(A_EN, d); check("R1", "enable after stray write", d, 8'hA5);
    rd(A_T1, d); check("R1", "type1 after stray write", d, 8'h0F);
    wr(A_EN, 8'h00); wr(A_T0, 8'h00); wr(A_T1, 8'h00); wr(A_T2, 8'h00);
    wr(A_ST, 8'hFF);
    chk_status("R6", 8'h00);
  endtask

  task automatic t_rise();
    wr(A_T0, 8'hFF); wr(A_T2, 8'h00); wr(A_ST, 8'hFF);
    pin_in = 8'h0F; tick();
    chk_status("R3", 8'h0F);
    check("R8", "irq with enable clear", W'(irq), '0);
    pin_in = 8'h00; tick();
    chk_status("R3", 8'h0F);
    wr(A_ST, 8'hFF);
    chk_status("R6", 8'h00);
  endtask

  task automatic t_fall();
    wr(A_T0, 8'h00); wr(A_T2, 8'hFF); wr(A_ST, 8'hFF);
    pin_in = 8'hFF; tick();
    chk_status("R3", 8'h00);
    pin_in = 8'h3C; tick();
    chk_status("R3", 8'hC3);
    wr(A_ST, 8'hFF);
  endtask

  task automatic t_both();
    wr(A_T0, 8'hFF); wr(A_T2, 8'hFF); wr(A_ST, 8'hFF);
    pin_in = 8'hF0; tick();
    chk_status("R4", 8'hCC);
    wr(A_ST, 8'hFF);
    pin_in = 8'h00; tick();
    chk_status("R4", 8'hF0);
  endtask

  task automatic t_w1c();
    wr(A_ST, 8'h30);
    chk_status("R6", 8'hC0);
    wr(A_ST, 8'h00);
    chk_status("R6", 8'hC0);
    wr(A_ST, 8'hFF);
    chk_status("R6", 8'h00);
  endtask

  task automatic t_level();
    wr(A_T2, 8'h00); wr(A_T0, 8'h0F); wr(A_T1, 8'hFF);
    pin_in = 8'h00; tick();
    chk_status("R5", 8'hF0);
    wr(A_ST, 8'hFF);
    chk_status("R5", 8'hF0);
    pin_in = 8'hF3; tick();
    chk_status("R5", 8'hF3);
    wr(A_ST, 8'hFF);
    chk_status("R5", 8'h03);
    pin_in = 8'hF0; wr(A_ST, 8'hFF);
    chk_status("R5", 8'h00);
  endtask

  task automatic t_same_cycle();
    wr(A_T1, 8'h00); wr(A_T0, 8'hFF);
    pin_in = 8'h00; tick();
    wr(A_ST, 8'hFF);
    chk_status("R7", 8'h00);
    pin_in = 8'h01; wr(A_ST, 8'hFF);
    chk_status("R7", 8'h01);
  endtask

  task automatic t_irq();
    wr(A_EN, 8'h01);
    check("R8", "irq enabled pending", W'(irq), 8'h01);
    wr(A_EN, 8'h02);
    check("R8", "irq other bit enabled", W'(irq), 8'h00);
    wr(A_EN, 8'hFF);
    check("R8", "irq all enabled", W'(irq), 8'h01);
    wr(A_ST, 8'h01);
    check("R8", "irq after clear", W'(irq), 8'h00);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    pin_in = 8'hFF;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    pin_in = 8'h00;
    tick();
    t_reset();
    t_cfg();
    t_rise();
    t_fall();
    t_both();
    t_w1c();
    t_level();
    t_same_cycle();
    t_irq();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule